// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous NRZ bit stream on a single output line. A one-character buffer register takes the next character from an 8-bit write port while a shift register sends the current one, so software can keep the line busy without gaps. Two status flags tell the two stages apart. `tx_rdy` reports that the buffer can take a character. `tx_empty` reports that the buffer and the shifter have both drained. The interrupt request follows `tx_rdy` when it is enabled.

Each frame consists of one start bit, then 1 to 8 data bits sent least significant bit first, then an optional even or odd parity bit, then an optional address bit for multiprocessor links, then one or two stop bits. The bit time comes from a 16-bit divisor. All frame settings and the divisor are taken when a frame starts. A transmit enable lets the current frame finish and then keeps the line idle.

The sequencer is a state machine with six states:

- IDLE: the line is high.
- START: sends the low start bit.
- DATA: sends the data bits.
- PARITY: sends the parity bit.
- ADDR: sends the address bit.
- STOP: sends one or two high stop bits.

Its transitions are:

- IDLE→START (load): the buffer is full and the transmitter is enabled.
- START→DATA: at the end of the bit.
- DATA→DATA: on every data bit except the last.
- DATA→PARITY: after the last data bit when parity is on.
- DATA→ADDR: after the last data bit when parity is off and address mode is on.
- DATA→STOP: after the last data bit when both are off.
- PARITY→ADDR: when address mode is on.
- PARITY→STOP: when address mode is off.
- ADDR→STOP: at the end of the bit.
- STOP→STOP: after the first of two stop bits.
- STOP→START (reload): after the final stop bit, with the buffer full and the transmitter enabled.
- STOP→IDLE: after the final stop bit otherwise.

Top module: `async_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_rdy` is 1, `tx_empty` is 1, and `tx_irq` equals `irq_en`.
- R2: Each bit lasts 16 clocks when `baud_div` is 0, and `(baud_div+1)*8` clocks otherwise. The value is captured when the frame starts.
- R3: A frame is sent in this order: a start bit of 0, then `word_len+1` data bits LSB first (`word_len` 0 means 1 bit, 7 means 8 bits), then the optional parity bit, then the optional address bit, then the stop bits of 1.
- R4: With `par_en` set, a parity bit is sent. With `par_odd` 0, the data bits plus the parity bit hold an even number of ones. With `par_odd` 1, they hold an odd number. The address bit is not counted.
- R5: With `addr_mode` set, one extra bit follows the data (and the parity, if present). Its value is `wr_addr_bit` as captured with the write of that character.
- R6: `stop_two` 1 gives two stop bit times; 0 gives one.
- R7: A character written while nothing is shifting starts its frame on the next clock edge, and `tx_rdy` is low for exactly one cycle. A character written during a frame starts its start bit directly after the last stop bit, with no idle time between.
- R8: A write while `tx_rdy` is 0 is discarded. The buffered character is sent unchanged, and the discarded one is never sent.
- R9: `tx_empty` is 1 exactly when no frame is in progress and the buffer is empty.
- R10: While `tx_en` is 0, no new frame starts. A frame already in progress completes, and the line then stays high.
- R11: `tx_irq` equals `irq_en` AND `tx_rdy`.
- R12: Word length, parity, address mode, stop count and divisor are sampled at the start of a frame. Changes during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the buffer register |
| wr_data | input | 8 | Character to send |
| wr_addr_bit | input | 1 | Address bit value captured with the character |
| tx_en | input | 1 | Transmit enable |
| irq_en | input | 1 | Interrupt enable |
| word_len | input | 3 | Data bits minus one |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_two | input | 1 | 1 = two stop bits |
| addr_mode | input | 1 | Insert the address bit |
| baud_div | input | 16 | Bit-rate divisor |
| txd | output | 1 | Serial output, idle high |
| tx_rdy | output | 1 | Buffer register can take a character |
| tx_empty | output | 1 | Buffer and shifter both idle |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The hardest case to reach from the ports is a write that arrives while the buffer is already full and the shifter is busy. It must be dropped, while the held character still starts exactly on the final stop edge. A close second is a transmit enable that drops in the middle of a frame while a character waits.

The stimulus reaches both cases by issuing two writes right after a third has been loaded. This leaves one character in the shifter, one in the buffer, and one rejected. In another frame it clears `tx_en` while the start bit is still on the line. A behavioural model built on queues predicts every line bit and every flag on every clock.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_ADDR,
        ST_STOP
    } tx_state_t;

    // frame settings captured at the start of a frame
    typedef struct packed {
        logic [2:0] wlen;
        logic       par_en;
        logic       par_bit;
        logic       addr_en;
        logic       addr_bit;
        logic       two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int LEN_W = DIV_W + 4;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_new;

    always_comb begin
        if (div == '0) begin
            len_new = LEN_W'(16);
        end else begin
            len_new = (LEN_W'(div) + LEN_W'(1)) << 3;
        end
    end

    assign tick = active && (cnt_q == len_q - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_W'(16);
            cnt_q <= '0;
        end else if (restart) begin
            len_q <= len_new;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // R2: the bit counter never runs past the latched bit length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < len_q));

endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_addr_bit,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              addr_bit
);
    logic accept;
    assign accept = wr_en && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full     <= 1'b0;
            data     <= '0;
            addr_bit <= 1'b0;
        end else if (accept) begin
            full     <= 1'b1;
            data     <= wr_data;
            addr_bit <= wr_addr_bit;
        end else if (take) begin
            full     <= 1'b0;
        end
    end

    // R8: a write into a full buffer leaves the stored character alone
    p_drop_full_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !take) |=> (full && $stable(data) && $stable(addr_bit)));

    // R7: a transfer to the shifter frees the buffer
    p_take_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !full);

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_addr,
    input  logic [WL_W-1:0]   word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_two,
    input  logic              addr_mode,
    input  logic              tick,
    output logic              load,
    output logic              active,
    output logic              txd
);
    localparam int IDX_W = WL_W;

    tx_state_t         state_q, state_d;
    frame_cfg_t        cfg_q;
    frame_cfg_t        cfg_new;
    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] mask;
    logic              last_stop;

    // parity over the selected data bits only
    always_comb begin
        mask             = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(word_len));
        cfg_new.wlen     = word_len;
        cfg_new.par_en   = par_en;
        cfg_new.par_bit  = (^(hold_data & mask)) ^ par_odd;
        cfg_new.addr_en  = addr_mode;
        cfg_new.addr_bit = hold_addr;
        cfg_new.two_stop = stop_two;
    end

    assign last_stop = (state_q == ST_STOP) && tick &&
                       (!cfg_q.two_stop || idx_q != '0);

    assign load = hold_full && tx_en &&
                  ((state_q == ST_IDLE) || last_stop);

    assign active = (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (load) begin
            state_d = ST_START;
            idx_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_START: begin
                    state_d = ST_DATA;
                    idx_d   = '0;
                end
                ST_DATA: begin
                    if (idx_q == cfg_q.wlen) begin
                        idx_d = '0;
                        if (cfg_q.par_en) begin
                            state_d = ST_PARITY;
                        end else if (cfg_q.addr_en) begin
                            state_d = ST_ADDR;
                        end else begin
                            state_d = ST_STOP;
                        end
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
                ST_PARITY: begin
                    state_d = cfg_q.addr_en ? ST_ADDR : ST_STOP;
                    idx_d   = '0;
                end
                ST_ADDR: begin
                    state_d = ST_STOP;
                    idx_d   = '0;
                end
                ST_STOP: begin
                    if (last_stop) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = IDX_W'(1);
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cfg_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (load) begin
                cfg_q <= cfg_new;
                sh_q  <= hold_data;
            end else if (tick && state_q == ST_DATA) begin
                sh_q  <= sh_q >> 1;
            end
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh_q[0];
            ST_PARITY: txd = cfg_q.par_bit;
            ST_ADDR:   txd = cfg_q.addr_bit;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    // R10: while disabled, no frame leaves the idle state
    p_no_start_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_en) |=> (state_q == ST_IDLE));

    // R3: the cycle after a frame starts the line is low
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);

    // R3: data index stays inside the configured word
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q <= cfg_q.wlen));

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    parameter int WL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_addr_bit,
    input  logic              tx_en,
    input  logic              irq_en,
    input  logic [WL_W-1:0]   word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_two,
    input  logic              addr_mode,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_empty,
    output logic              tx_irq
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_addr;
    logic              load;
    logic              active;
    logic              tick;

    async_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .wr_addr_bit (wr_addr_bit),
        .take        (load),
        .full        (hold_full),
        .data        (hold_data),
        .addr_bit    (hold_addr)
    );

    async_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .active  (active),
        .div     (baud_div),
        .tick    (tick)
    );

    async_tx_shift #(.DATA_W(DATA_W), .WL_W(WL_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .hold_addr (hold_addr),
        .word_len  (word_len),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop_two  (stop_two),
        .addr_mode (addr_mode),
        .tick      (tick),
        .load      (load),
        .active    (active),
        .txd       (txd)
    );

    assign tx_rdy   = !hold_full;
    assign tx_empty = !hold_full && !active;
    assign tx_irq   = irq_en && tx_rdy;

    // R9: an empty transmitter holds the line at the idle level
    p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (txd && tx_rdy));

    // R7: a write accepted into an idle, enabled transmitter starts a frame next edge
    p_write_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_empty && tx_en) |=> (!tx_rdy && !tx_empty));

endmodule

// File: tb/test_async_tx.sv
module test_async_tx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_addr_bit = 1'b0;
    logic        tx_en = 1'b0;
    logic        irq_en = 1'b0;
    logic [2:0]  word_len = 3'd7;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        stop_two = 1'b0;
    logic        addr_mode = 1'b0;
    logic [15:0] baud_div = '0;
    logic        txd, tx_rdy, tx_empty, tx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_tx i_async_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_addr_bit(wr_addr_bit), .tx_en(tx_en), .irq_en(irq_en),
        .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
        .stop_two(stop_two), .addr_mode(addr_mode), .baud_div(baud_div),
        .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .tx_irq(tx_irq)
    );

    // ---------------- behavioural reference model ----------------
    bit m_full = 0;
    bit [7:0] m_data = '0;
    bit m_abit = 0;
    bit m_busy = 0;
    bit m_q[$];
    int m_cnt = 0;
    int m_blen = 16;

    task automatic build_frame();
        int nb;
        int ones;
        m_q.delete();
        nb = int'(word_len) + 1;
        ones = 0;
        m_q.push_back(1'b0);                         // R3 start bit
        for (int i = 0; i < nb; i++) begin           // R3 LSB first
            m_q.push_back(m_data[i]);
            ones += int'(m_data[i]);
        end
        if (par_en) m_q.push_back(bit'(ones % 2) ^ par_odd);  // R4
        if (addr_mode) m_q.push_back(m_abit);                 // R5
        m_q.push_back(1'b1);                                  // R6
        if (stop_two) m_q.push_back(1'b1);
        m_blen = (baud_div == 0) ? 16 : (int'(baud_div) + 1) * 8;   // R2, R12
        m_cnt = 0;
        m_busy = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_full = 0; m_busy = 0; m_cnt = 0; m_q.delete();
        end else begin
            bit pre_full;
            bit pre_busy;
            bit finishing;
            pre_full = m_full;
            pre_busy = m_busy;
            finishing = 0;
            if (m_busy) begin
                if (m_cnt == m_blen - 1) begin
                    void'(m_q.pop_front());
                    m_cnt = 0;
                    if (m_q.size() == 0) begin
                        m_busy = 0;
                        finishing = 1;
                    end
                end else begin
                    m_cnt++;
                end
            end
            if ((!pre_busy || finishing) && pre_full && tx_en) begin  // R7, R10
                build_frame();
                m_full = 0;
            end
            if (wr_en && !pre_full) begin                             // R8
                m_full = 1;
                m_data = wr_data;
                m_abit = wr_addr_bit;
            end
        end
    end

    // ---------------- comparison, a quarter period after each edge ----------------
    task automatic check1(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        cycles++;
        if (rst_n) begin
            bit e_txd;
            e_txd = m_busy ? m_q[0] : 1'b1;
            check1("R3 txd", txd, e_txd);
            check1("R7 tx_rdy", tx_rdy, !m_full);
            check1("R9 tx_empty", tx_empty, !m_full && !m_busy);
            check1("R11 tx_irq", tx_irq, irq_en && !m_full);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(logic [7:0] d, logic a);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_addr_bit = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        int guard;
        guard = 0;
        while (!(tx_empty === 1'b1) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        tick_n(3);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        // R1: reset state
        tick_n(3);
        check1("R1 txd", txd, 1'b1);
        check1("R1 tx_rdy", tx_rdy, 1'b1);
        check1("R1 tx_empty", tx_empty, 1'b1);
        check1("R1 tx_irq", tx_irq, 1'b0);
        rst_n = 1'b1;
        tick_n(2);
        tx_en = 1'b1;
        irq_en = 1'b1;

        // R2 R3 R7: 8 data bits, no parity, one stop, divisor 0 (16 clocks)
        put(8'hA5, 1'b0);
        wait_empty();

        // R4 R6: 5 bits, even parity, two stops, divisor 1 (16 clocks)
        word_len = 3'd4; par_en = 1'b1; par_odd = 1'b0; stop_two = 1'b1; baud_div = 16'd1;
        put(8'h13, 1'b0);
        wait_empty();

        // R4 R5: 7 bits, odd parity, address bit set, divisor 2 (24 clocks)
        word_len = 3'd6; par_odd = 1'b1; stop_two = 1'b0; addr_mode = 1'b1; baud_div = 16'd2;
        put(8'h5C, 1'b1);
        wait_empty();

        // R5: address bit without parity, value 0
        par_en = 1'b0;
        put(8'h3F, 1'b0);
        wait_empty();

        // R7 R8: back-to-back frames, third write discarded while buffer full
        addr_mode = 1'b0; word_len = 3'd7; baud_div = 16'd0;
        put(8'h81, 1'b0);
        put(8'h42, 1'b0);
        put(8'hFF, 1'b0);
        // R12: change word length and divisor while the first frame runs
        word_len = 3'd2; baud_div = 16'd3;
        wait_empty();

        // R11: interrupt disabled masks the request
        irq_en = 1'b0;
        word_len = 3'd0; baud_div = 16'd0;
        put(8'h01, 1'b0);       // 1-bit word boundary (R3)
        wait_empty();
        irq_en = 1'b1;

        // R10: clear enable during a frame with a character waiting
        word_len = 3'd7;
        put(8'hC3, 1'b0);
        put(8'h3C, 1'b0);
        tx_en = 1'b0;
        tick_n(400);
        // frame finished, line idle, buffer still holds a character (R9)
        check1("R10 txd idle", txd, 1'b1);
        check1("R9 not empty", tx_empty, 1'b0);
        tx_en = 1'b1;
        wait_empty();

        // R10: enable low before any write: nothing starts
        tx_en = 1'b0;
        put(8'h99, 1'b1);
        tick_n(50);
        check1("R10 held", txd, 1'b1);
        check1("R10 rdy low", tx_rdy, 1'b0);
        tx_en = 1'b1;
        wait_empty();

        done = 1;
        finish_run();
    end

    initial begin
        while (cycles < WATCHDOG && !done) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule